// File: doc/BRIEF.md
# Dual-Channel Audio Pause Detector

This block watches a stereo stream of signed PCM samples and decides whether the tape under the head is carrying music or sitting in a gap between tracks. A transport controller uses that decision while it spools the tape fast. The detector takes the magnitude of each channel and adds the two, so a pair whose polarities are opposed still registers. The sum is smoothed into an envelope by a first-order recursive filter. A comparator with separate rising and falling thresholds then turns the envelope into a raw loud/quiet level.

Two timers qualify the raw level before the search-status output changes. A rise timer sets how long the level must stay loud before the output reports music. A delay timer sets how long it must stay quiet before the output reports a pause. Both timers advance on a one-cycle millisecond tick. A mode input selects one of three settings. Off holds the output HIGH. Scan reports music and pause directly. Latch holds the output HIGH until the first music is heard and uses a much longer onset time, so that pops on the tape do not stop the transport. A noise-reduction enable flag is also driven, and it is dropped whenever a search mode is active.

Top module: `music_pause_detector`

## Requirements
- R1: Each channel is rectified before the two are summed. A left sample of +A with a right sample of -A therefore produces the same envelope as +A on both channels, and it is detected as music.
- R2: The raw level turns loud only when the envelope reaches `thr_music` (linear, unsigned). It turns quiet only when the envelope drops below `thr_pause`. An envelope between the two thresholds keeps the previous level, whichever it was.
- R3: In scan mode `search_out` is 1 while qualified music is present and 0 during a qualified pause.
- R4: `search_out` goes from 0 to 1 on the `rise_ms`-th tick of an unbroken loud level. This applies in scan mode, and a value of 0 behaves as 1. A loud burst shorter than that leaves the output at 0.
- R5: `search_out` goes from 1 to 0 on the `delay_ms`-th tick of an unbroken quiet level. A quiet gap shorter than that leaves the output at 1. Any return of the level to agreement with the output restarts the count.
- R6: `delay_ms` is an 8-bit tick count. It covers at least 23 to 160 ms.
- R7: Entering scan mode sets `search_out` to 1 from the next cycle. If the level is quiet at entry, the output drops to 0 after `delay_ms` ticks. If it is loud, the output stays at 1.
- R8: In latch mode the onset time is fixed at `LATCH_RISE_MS` ticks (default 150) instead of `rise_ms`.
- R9: Entering latch mode forces `search_out` to 1 until music is first qualified. After that the output follows the qualified state. The hold is armed again only by a fresh entry into latch mode.
- R10: The mode encoding is 2'b00 off, 2'b01 scan, 2'b10 latch, and 2'b11 off. In off mode `search_out` is 1. `nr_enable` is 1 exactly when the mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond, paces both timers |
| smp_valid | input | 1 | A new stereo sample pair is present |
| smp_left | input | W | Left channel sample, two's complement |
| smp_right | input | W | Right channel sample, two's complement |
| mode | input | 2 | 00 off, 01 scan, 10 latch, 11 off |
| thr_music | input | W+1 | Envelope level at which the raw level turns loud |
| thr_pause | input | W+1 | Envelope level below which the raw level turns quiet |
| rise_ms | input | TW | Scan-mode onset time in ticks |
| delay_ms | input | TW | Pause time in ticks |
| search_out | output | 1 | Search status: 1 music or held, 0 pause |
| nr_enable | output | 1 | Noise-reduction enable, 0 whenever searching |

## Verification
The timer-bound assertion relies on `rise_ms` and `delay_ms` holding steady while a count is running. It also relies on `thr_pause` not exceeding `thr_music`. The stimulus respects both conditions by changing the timing inputs only while the level agrees with the output, when both timers are at zero. The thresholds are set once. Each level step lets the envelope settle with the tick held low, so every tick the bench then issues falls on a settled level and its count can be predicted exactly. Mode changes are applied for several ticks-free cycles before any tick is sent.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SCAN  = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_RSVD  = 2'b11
  } mpd_mode_e;
endpackage

// File: rtl/mpd_envelope.sv
module mpd_envelope #(
  parameter int W     = 16,
  parameter int SHIFT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic signed [W-1:0] left,
  input  logic signed [W-1:0] right,
  output logic [W:0]          env
);
  localparam int EW = W + 1;

  logic signed [W-1:0] chan [2];
  logic [W-1:0]        mag  [2];
  logic [EW-1:0]       sum;
  logic signed [EW:0]  diff, step, env_nxt;
  logic [EW-1:0]       env_q, env_d;

  assign chan[0] = left;
  assign chan[1] = right;

  // rectify each channel; the most negative code maps to 2^(W-1)
  for (genvar i = 0; i < 2; i++) begin : g_rect
    assign mag[i] = chan[i][W-1] ? $unsigned(-chan[i]) : $unsigned(chan[i]);
  end

  always_comb begin
    sum     = {1'b0, mag[0]} + {1'b0, mag[1]};
    diff    = $signed({1'b0, sum}) - $signed({1'b0, env_q});
    step    = diff >>> SHIFT;
    env_nxt = $signed({1'b0, env_q}) + step;
    env_d   = env_nxt[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     env_q <= '0;
    else if (valid) env_q <= env_d;
  end

  assign env = env_q;

  // smoothed value stays within the unsigned range of the rectified sum
  assert_env_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !env_nxt[EW]);
endmodule

// File: rtl/mpd_level_cmp.sv
module mpd_level_cmp #(
  parameter int EW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] env,
  input  logic [EW-1:0] thr_up,
  input  logic [EW-1:0] thr_dn,
  output logic          loud
);
  logic loud_q, loud_d;

  always_comb begin
    if (loud_q) loud_d = !(env < thr_dn);
    else        loud_d = (env >= thr_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loud_q <= 1'b0;
    else        loud_q <= loud_d;
  end

  assign loud = loud_q;

  assert_rise_at_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loud_q) |-> $past(env >= thr_up));
  assert_fall_below_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loud_q) |-> $past(env < thr_dn));
endmodule

// File: rtl/mpd_qualifier.sv
module mpd_qualifier #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          loud,
  input  logic          restart,
  input  logic          restart_val,
  input  logic [TW-1:0] rise_lim,
  input  logic [TW-1:0] delay_lim,
  output logic          music
);
  logic          st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] lim, lim_eff;
  logic [TW:0]   cnt_inc;

  always_comb begin
    lim     = st_q ? delay_lim : rise_lim;
    lim_eff = (lim == '0) ? TW'(1) : lim;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    st_d    = st_q;
    cnt_d   = cnt_q;
    if (restart) begin
      st_d  = restart_val;
      cnt_d = '0;
    end else if (loud == st_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, lim_eff}) begin
        st_d  = !st_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign music = st_q;

  assert_music_needs_loud_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(restart) && $rose(st_q)) |-> ($past(loud) && $past(tick)));
  assert_pause_needs_quiet_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(restart) && $fell(st_q)) |-> (!$past(loud) && $past(tick)));
  assert_count_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_eff);
endmodule

// File: rtl/music_pause_detector.sv
module music_pause_detector
  import mpd_pkg::*;
#(
  parameter int W             = 16,
  parameter int ENV_SHIFT     = 3,
  parameter int TW            = 8,
  parameter int LATCH_RISE_MS = 150
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_ms,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_left,
  input  logic signed [W-1:0] smp_right,
  input  logic [1:0]          mode,
  input  logic [W:0]          thr_music,
  input  logic [W:0]          thr_pause,
  input  logic [TW-1:0]       rise_ms,
  input  logic [TW-1:0]       delay_ms,
  output logic                search_out,
  output logic                nr_enable
);
  localparam int            EW        = W + 1;
  localparam logic [TW-1:0] LATCH_LIM = TW'(LATCH_RISE_MS);

  mpd_mode_e     mode_n, mode_q;
  logic          active, entry, restart, restart_val;
  logic          latch_q, latch_d;
  logic          loud, music;
  logic [EW-1:0] env;
  logic [TW-1:0] rise_sel;

  always_comb begin
    mode_n      = (mpd_mode_e'(mode) == MODE_SCAN || mpd_mode_e'(mode) == MODE_LATCH)
                  ? mpd_mode_e'(mode) : MODE_OFF;
    active      = (mode_n != MODE_OFF);
    entry       = active && (mode_n != mode_q);
    restart     = entry || !active;
    restart_val = (mode_n != MODE_LATCH);
    rise_sel    = (mode_n == MODE_LATCH) ? LATCH_LIM : rise_ms;
    if (entry)        latch_d = (mode_n == MODE_LATCH);
    else if (!active) latch_d = 1'b0;
    else              latch_d = latch_q && !music;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      latch_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      latch_q <= latch_d;
    end
  end

  mpd_envelope #(.W(W), .SHIFT(ENV_SHIFT)) u_env (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid),
    .left(smp_left), .right(smp_right), .env(env));

  mpd_level_cmp #(.EW(EW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .env(env),
    .thr_up(thr_music), .thr_dn(thr_pause), .loud(loud));

  mpd_qualifier #(.TW(TW)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .loud(loud),
    .restart(restart), .restart_val(restart_val),
    .rise_lim(rise_sel), .delay_lim(delay_ms), .music(music));

  assign search_out = music || latch_q;
  assign nr_enable  = !active;

  assert_off_holds_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> search_out);
  assert_entry_starts_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(entry) |-> search_out);
  assert_latch_clears_on_music_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(latch_q) && $past(active) && !$past(entry)) |-> $past(music));
endmodule

// File: tb/sim_music_pause_detector.sv
module sim_music_pause_detector;
  localparam int W  = 16;
  localparam int TW = 8;

  logic                clk = 1'b0;
  logic                rst_n, tick_ms, smp_valid;
  logic signed [W-1:0] smp_left, smp_right;
  logic [1:0]          mode;
  logic [W:0]          thr_music, thr_pause;
  logic [TW-1:0]       rise_ms, delay_ms;
  logic                search_out, nr_enable;
  int                  checks = 0;
  int                  errors = 0;
  bit                  done   = 1'b0;

  always #2 clk = ~clk;

  music_pause_detector u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .mode(mode),
    .thr_music(thr_music), .thr_pause(thr_pause),
    .rise_ms(rise_ms), .delay_ms(delay_ms),
    .search_out(search_out), .nr_enable(nr_enable));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // new sample level, then let the envelope settle with no tick
  task automatic set_level(input int l, input int r);
    @(negedge clk);
    smp_left  = W'(l);
    smp_right = W'(r);
    repeat (200) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) mode = m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; smp_valid = 1'b1;
    smp_left = '0; smp_right = '0; mode = 2'b00;
    thr_music = 17'd4000; thr_pause = 17'd3000;
    rise_ms = 8'd6; delay_ms = 8'd23;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(search_out, 1'b1, "R10 reset out");
    check(nr_enable, 1'b1, "R10 reset nr");
    ticks(50);
    check(search_out, 1'b1, "R10 off holds high");
    set_mode(2'b11);
    check(nr_enable, 1'b1, "R10 code 11 is off");
    check(search_out, 1'b1, "R10 code 11 out");

    // scan entry without signal
    set_mode(2'b01);
    check(nr_enable, 1'b0, "R10 nr off in scan");
    ticks(22);
    check(search_out, 1'b1, "R7 high during settling");
    ticks(1);
    check(search_out, 1'b0, "R7 low after delay");

    // short burst, then real onset
    set_level(3000, 3000);
    ticks(5);
    check(search_out, 1'b0, "R4 5 of 6");
    set_level(0, 0);
    ticks(10);
    check(search_out, 1'b0, "R4 burst rejected");
    set_level(3000, 3000);
    ticks(5);
    check(search_out, 1'b0, "R4 still low");
    ticks(1);
    check(search_out, 1'b1, "R3 music high");

    // interruption shorter than delay, restart on reversal
    set_level(0, 0);
    ticks(22);
    check(search_out, 1'b1, "R5 gap 22");
    set_level(3000, 3000);
    set_level(0, 0);
    ticks(22);
    check(search_out, 1'b1, "R5 count restarted");
    ticks(1);
    check(search_out, 1'b0, "R3 pause low");

    // opposite polarity
    set_level(3000, -3000);
    ticks(5);
    check(search_out, 1'b0, "R1 before rise");
    ticks(1);
    check(search_out, 1'b1, "R1 inverted detected");

    // hysteresis band in both directions
    set_level(1750, 1750);
    ticks(40);
    check(search_out, 1'b1, "R2 mid from loud");
    set_level(0, 0);
    ticks(23);
    check(search_out, 1'b0, "R2 quiet");
    set_level(3500, 0);
    ticks(40);
    check(search_out, 1'b0, "R2 mid from quiet");

    // long delay and a changed rise time
    delay_ms = 8'd160;
    rise_ms  = 8'd10;
    set_level(3000, 3000);
    ticks(9);
    check(search_out, 1'b0, "R4 rise 10 at 9");
    ticks(1);
    check(search_out, 1'b1, "R4 rise 10 at 10");
    set_level(0, 0);
    ticks(159);
    check(search_out, 1'b1, "R6 delay 160 at 159");
    ticks(1);
    check(search_out, 1'b0, "R6 delay 160 at 160");
    delay_ms = 8'd23;
    rise_ms  = 8'd6;

    // latch entry without signal
    set_mode(2'b10);
    check(nr_enable, 1'b0, "R10 nr off in latch");
    ticks(300);
    check(search_out, 1'b1, "R9 held before music");
    set_level(3000, 3000);
    ticks(150);
    check(search_out, 1'b1, "R9 high at first music");
    set_level(0, 0);
    ticks(22);
    check(search_out, 1'b1, "R9 gap 22");
    ticks(1);
    check(search_out, 1'b0, "R9 released, pause low");
    set_level(3000, 3000);
    ticks(149);
    check(search_out, 1'b0, "R8 latch rise at 149");
    ticks(1);
    check(search_out, 1'b1, "R8 latch rise at 150");
    set_level(0, 0);
    ticks(23);
    set_level(3000, 3000);
    ticks(100);
    set_level(0, 0);
    ticks(10);
    check(search_out, 1'b0, "R8 100 tick burst rejected");

    // latch entry with signal
    set_mode(2'b00);
    set_level(3000, 3000);
    set_mode(2'b10);
    ticks(149);
    check(search_out, 1'b1, "R9 entry loud 149");
    ticks(51);
    check(search_out, 1'b1, "R9 entry loud 200");
    set_level(0, 0);
    ticks(23);
    check(search_out, 1'b0, "R9 released after music");

    // re-entry arms the hold again
    set_mode(2'b00);
    set_mode(2'b10);
    ticks(100);
    check(search_out, 1'b1, "R9 re-armed");

    // scan entry with signal
    set_mode(2'b00);
    set_level(3000, 3000);
    set_mode(2'b01);
    ticks(100);
    check(search_out, 1'b1, "R7 entry loud stays high");

    set_mode(2'b00);
    check(search_out, 1'b1, "R10 back off out");
    check(nr_enable, 1'b1, "R10 back off nr");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule